// File: doc/BRIEF.md
# Serial Word Alignment Shift Register

This block holds the receive and transmit shift registers of a 24-bit synchronous serial port. Serial data moves most significant bit first, one bit for each cycle in which the bit-clock enable is high. A word starts with the bit that arrives together with frame sync. The receive side collects a word of the selected length and presents it as a parallel 24-bit value. The transmit side loads a parallel word and shifts it out, starting from the top bit of the selected alignment.

A configuration bit moves the left-alignment point from bit 23 down to bit 15, so that 16-bit fractional data can be used without repacking. Hardware reset clears this bit, and so does a software reset strobe. With the bit set, only 8-, 12- and 16-bit words are valid. If a longer length is chosen in that mode, the block raises an error output and aligns to bit 23.

Top module: `serial_align_shifter`

## Requirements
- R1: Word length code `cfgLen` (0=8, 1=12, 2=16, 3=24, 4 to 7=32 bits) and the alignment bit are written together when `cfgWe` is high. Hardware reset clears the alignment bit and sets the length code to 0 (8 bits).
- R2: A cycle with `bitEn` and `frameSync` both high captures the first (most significant) bit of a word. Each later `bitEn` cycle captures the next bit. `rxValid` is high for exactly the one cycle after the clock edge that captures the last bit. `rxWord` keeps its value until the next word completes.
- R3: With the alignment bit clear, the received word's MSB lands at `rxWord[23]` and the bits below the word are zero. A 32-bit word keeps its first 24 bits.
- R4: With the alignment bit set and an 8-, 12- or 16-bit length, the word's MSB lands at `rxWord[15]`. The bits below the word are zero, and `rxWord[23:16]` is zero.
- R5: `lenError` is high exactly when the alignment bit is set and the length code is 3 or higher. In that case both directions align to bit 23.
- R6: A `softRst` pulse clears the alignment bit and leaves the length code unchanged. It overrides a `cfgWe` write in the same cycle.
- R7: `txLoad` captures `txWord`. On the clock edge of a frame-sync bit, `txBit` takes the value of `txWord[23]`, or of `txWord[15]` when aligning low. Each later `bitEn` edge presents the next lower bit. Zeros follow bit 0.
- R8: Frame sync in the middle of a word discards the partial word and starts a new one. A `bitEn` with no word in progress produces no `rxValid` and leaves `rxWord` unchanged.
- R9: In cycles with `bitEn` low, neither shift register moves and `txBit` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAlign | input | 1 | Alignment bit value (1 = align to bit 15) |
| cfgLen | input | 3 | Word length code |
| softRst | input | 1 | Software reset strobe, clears alignment bit |
| bitEn | input | 1 | Bit-clock enable, one bit per high cycle |
| frameSync | input | 1 | Marks the first bit of a word (qualified by bitEn) |
| rxBit | input | 1 | Serial receive data |
| txLoad | input | 1 | Load strobe for the transmit word |
| txWord | input | 24 | Parallel transmit word |
| rxWord | output | 24 | Aligned received word |
| rxValid | output | 1 | One-cycle pulse when a word completes |
| txBit | output | 1 | Serial transmit data |
| alignBit | output | 1 | Current alignment bit |
| lenError | output | 1 | Invalid length for the low alignment |

## Verification
The assertions assume that configuration is not rewritten while a word is being received, so that the length and alignment seen at `rxValid` are the ones that shaped the word. They also assume that frames are at least two bit periods apart, so that `rxValid` cannot be followed at once by another completion. The stimulus always writes configuration before a frame starts. It spaces bits with random idle gaps and sends each word in full, except in the one directed case where a frame is restarted on purpose.

// File: rtl/sas_pkg.sv
package sas_pkg;

  typedef struct packed {
    logic rxStart;
    logic rxShift;
    logic rxDone;
    logic txStart;
    logic txShift;
  } strobe_t;

  function automatic int lenOf(input logic [2:0] code);
    case (code)
      3'd0:    return 8;
      3'd1:    return 12;
      3'd2:    return 16;
      3'd3:    return 24;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/sas_ctrl.sv
module sas_ctrl
  import sas_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic             cfgAlign,
  input  logic [LEN_W-1:0] cfgLen,
  input  logic             softRst,
  input  logic             bitEn,
  input  logic             frameSync,
  output strobe_t          strb,
  output logic             alignBit,
  output logic [LEN_W-1:0] lenCode,
  output logic             msbLow,
  output logic             lenError
);
  localparam int CNT_W = $clog2(ACC_W + 1);
  localparam logic [LEN_W-1:0] MAX_LOW_CODE = LEN_W'(2);

  logic             rxActive;
  logic [CNT_W-1:0] rxCnt;
  logic [CNT_W-1:0] nextCnt;
  logic [CNT_W-1:0] wordBits;

  // configuration register; software reset wins over a write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alignBit <= 1'b0;
      lenCode  <= '0;
    end else begin
      if (cfgWe) begin
        lenCode  <= cfgLen;
        alignBit <= cfgAlign;
      end
      if (softRst) alignBit <= 1'b0;
    end
  end

  assign lenError = alignBit && (lenCode > MAX_LOW_CODE);
  assign msbLow   = alignBit && !lenError;

  assign nextCnt  = rxCnt + 1'b1;
  assign wordBits = CNT_W'(lenOf(lenCode));

  always_comb begin
    strb.rxStart = bitEn && frameSync;
    strb.rxShift = bitEn && !frameSync && rxActive;
    strb.rxDone  = strb.rxShift && (nextCnt == wordBits);
    strb.txStart = bitEn && frameSync;
    strb.txShift = bitEn && !frameSync;
  end

  // receive bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxActive <= 1'b0;
      rxCnt    <= '0;
    end else if (strb.rxStart) begin
      rxActive <= 1'b1;
      rxCnt    <= CNT_W'(1);
    end else if (strb.rxShift) begin
      rxCnt <= nextCnt;
      if (strb.rxDone) rxActive <= 1'b0;
    end
  end

endmodule

// File: rtl/sas_datapath.sv
module sas_datapath
  import sas_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int ACC_W   = 32,
  parameter int LOW_MSB = 15,
  parameter int LEN_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              msbLow,
  input  logic [LEN_W-1:0]  lenCode,
  input  logic              rxBit,
  input  logic              txLoad,
  input  logic [DATA_W-1:0] txWord,
  output logic [DATA_W-1:0] rxWord,
  output logic              rxValid,
  output logic              txBit
);
  localparam int PAD_W     = ACC_W - DATA_W;
  localparam int LOW_SHIFT = DATA_W - 1 - LOW_MSB;

  logic [ACC_W-2:0]  acc;
  logic [ACC_W-1:0]  accNext;
  logic [DATA_W-1:0] alignedWord;
  logic [DATA_W-1:0] txHold;
  logic [ACC_W-1:0]  txShreg;
  logic [ACC_W-1:0]  txStartVal;
  int                nBits;
  int                topBits;

  // receive collector: a new frame clears the stale upper bits
  assign accNext = strb.rxStart ? {{(ACC_W-1){1'b0}}, rxBit} : {acc, rxBit};

  always_comb begin
    nBits   = lenOf(lenCode);
    topBits = msbLow ? (LOW_MSB + 1) : DATA_W;
    if (nBits > topBits) alignedWord = DATA_W'(accNext >> (nBits - topBits));
    else                 alignedWord = DATA_W'(accNext << (topBits - nBits));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc     <= '0;
      rxWord  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= strb.rxDone;
      if (strb.rxStart || strb.rxShift) acc <= accNext[ACC_W-2:0];
      if (strb.rxDone) rxWord <= alignedWord;
    end
  end

  // transmit: move the selected MSB to the serial output position
  assign txStartVal = ACC_W'({txHold, {PAD_W{1'b0}}} << (msbLow ? LOW_SHIFT : 0));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold  <= '0;
      txShreg <= '0;
    end else begin
      if (txLoad) txHold <= txWord;
      if (strb.txStart)      txShreg <= txStartVal;
      else if (strb.txShift) txShreg <= {txShreg[ACC_W-2:0], 1'b0};
    end
  end

  assign txBit = txShreg[ACC_W-1];

endmodule

// File: rtl/serial_align_shifter.sv
module serial_align_shifter
  import sas_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int ACC_W   = 32,
  parameter int LOW_MSB = 15,
  parameter int LEN_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic              cfgAlign,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic              softRst,
  input  logic              bitEn,
  input  logic              frameSync,
  input  logic              rxBit,
  input  logic              txLoad,
  input  logic [DATA_W-1:0] txWord,
  output logic [DATA_W-1:0] rxWord,
  output logic              rxValid,
  output logic              txBit,
  output logic              alignBit,
  output logic              lenError
);
  strobe_t          strb;
  logic [LEN_W-1:0] lenCode;
  logic             msbLow;

  sas_ctrl #(.ACC_W(ACC_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAlign(cfgAlign), .cfgLen(cfgLen),
    .softRst(softRst), .bitEn(bitEn), .frameSync(frameSync), .strb(strb),
    .alignBit(alignBit), .lenCode(lenCode), .msbLow(msbLow), .lenError(lenError)
  );

  sas_datapath #(.DATA_W(DATA_W), .ACC_W(ACC_W), .LOW_MSB(LOW_MSB), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .msbLow(msbLow), .lenCode(lenCode),
    .rxBit(rxBit), .txLoad(txLoad), .txWord(txWord), .rxWord(rxWord),
    .rxValid(rxValid), .txBit(txBit)
  );

endmodule

// File: rtl/sas_checker.sv
module sas_checker #(
  parameter int DATA_W = 24,
  parameter int LEN_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              softRst,
  input logic              bitEn,
  input logic [LEN_W-1:0]  lenCode,
  input logic [DATA_W-1:0] rxWord,
  input logic              rxValid,
  input logic              txBit,
  input logic              alignBit,
  input logic              lenError
);

  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  assert_valid_after_bit_R2: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $past(bitEn));

  assert_zero_fill_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !alignBit && lenCode == '0) |-> (rxWord[DATA_W-9:0] == '0));

  assert_high_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && alignBit && !lenError) |-> (rxWord[DATA_W-1:16] == '0));

  assert_err_needs_align_R5: assert property (@(posedge clk) disable iff (!rstN)
    lenError |-> alignBit);

  assert_soft_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> !alignBit);

  assert_tx_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> $stable(txBit));

endmodule

bind serial_align_shifter sas_checker #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .softRst(softRst), .bitEn(bitEn), .lenCode(lenCode),
  .rxWord(rxWord), .rxValid(rxValid), .txBit(txBit), .alignBit(alignBit),
  .lenError(lenError)
);

// File: tb/serial_align_shifter_tb.sv
`timescale 1ns/1ps
module serial_align_shifter_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0, cfgAlign = 1'b0, softRst = 1'b0;
  logic [2:0]  cfgLen = '0;
  logic        bitEn = 1'b0, frameSync = 1'b0, rxBit = 1'b0, txLoad = 1'b0;
  logic [23:0] txWord = '0;
  logic [23:0] rxWord;
  logic        rxValid, txBit, alignBit, lenError;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  serial_align_shifter u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAlign(cfgAlign), .cfgLen(cfgLen),
    .softRst(softRst), .bitEn(bitEn), .frameSync(frameSync), .rxBit(rxBit),
    .txLoad(txLoad), .txWord(txWord), .rxWord(rxWord), .rxValid(rxValid),
    .txBit(txBit), .alignBit(alignBit), .lenError(lenError)
  );

  function automatic int bitsOf(input int code);
    if (code == 0) return 8;
    if (code == 1) return 12;
    if (code == 2) return 16;
    if (code == 3) return 24;
    return 32;
  endfunction

  function automatic bit lowAlign(input int code, input bit al);
    return al && (code <= 2);
  endfunction

  function automatic logic [23:0] expRx(input int code, input bit al, input logic [31:0] v);
    int n = bitsOf(code);
    int top = lowAlign(code, al) ? 16 : 24;
    logic [31:0] m = (n == 32) ? v : (v & ((32'd1 << n) - 1));
    logic [31:0] r = (n > top) ? (m >> (n - top)) : (m << (top - n));
    return r[23:0];
  endfunction

  function automatic logic expTx(input int code, input bit al, input logic [23:0] w, input int k);
    int pos = (lowAlign(code, al) ? 15 : 23) - k;
    return (pos >= 0) ? w[pos] : 1'b0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeCfg(input bit al, input int code);
    @(negedge clk);
    cfgWe = 1'b1; cfgAlign = al; cfgLen = 3'(code);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic bitStep(input logic fs, input logic b, input int gap);
    repeat (gap) @(negedge clk);
    @(negedge clk);
    bitEn = 1'b1; frameSync = fs; rxBit = b;
    @(negedge clk);
    bitEn = 1'b0; frameSync = 1'b0; rxBit = 1'b0;
  endtask

  task automatic sendRx(input bit doCfg, input bit al, input int code,
                        input logic [31:0] v, input string req);
    int n = bitsOf(code);
    logic [23:0] e = expRx(code, al, v);
    if (doCfg) writeCfg(al, code);
    for (int k = 0; k < n; k++) begin
      bitStep(k == 0, v[n-1-k], $urandom_range(0, 2));
      if (k < n - 1) chk({req, " R2 early valid"}, {31'd0, rxValid}, 32'd0);
    end
    chk({req, " R2 valid"}, {31'd0, rxValid}, 32'd1);
    chk({req, " word"}, {8'd0, rxWord}, {8'd0, e});
    @(negedge clk);
    chk({req, " R2 pulse ends"}, {31'd0, rxValid}, 32'd0);
    chk({req, " R2 held"}, {8'd0, rxWord}, {8'd0, e});
  endtask

  task automatic sendTx(input bit al, input int code, input logic [23:0] w, input bit holdChk);
    writeCfg(al, code);
    @(negedge clk);
    txLoad = 1'b1; txWord = w;
    @(negedge clk);
    txLoad = 1'b0; txWord = $urandom();
    for (int k = 0; k < 32; k++) begin
      bitStep(k == 0, 1'b0, $urandom_range(0, 2));
      chk("R7 tx bit", {31'd0, txBit}, {31'd0, expTx(code, al, w, k)});
      if (holdChk && k == 4) begin
        for (int i = 0; i < 3; i++) begin
          @(negedge clk);
          chk("R9 tx hold", {31'd0, txBit}, {31'd0, expTx(code, al, w, k)});
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    chk("R1 reset align", {31'd0, alignBit}, 32'd0);
    chk("R5 reset err", {31'd0, lenError}, 32'd0);
    chk("R2 reset valid", {31'd0, rxValid}, 32'd0);
    chk("R7 reset tx", {31'd0, txBit}, 32'd0);
    chk("R2 reset word", {8'd0, rxWord}, 32'd0);

    // R1: default length 8 after reset, no configuration write
    sendRx(1'b0, 1'b0, 0, 32'h0000_00C3, "R1 default len");

    // R3 directed: each length, high alignment
    sendRx(1'b1, 1'b0, 1, 32'h0000_0ABC, "R3 len12");
    sendRx(1'b1, 1'b0, 3, 32'h00F0_0F5A, "R3 len24");
    sendRx(1'b1, 1'b0, 4, 32'h8123_4567, "R3 len32");

    // R4 directed: low alignment
    sendRx(1'b1, 1'b1, 0, 32'h0000_00FF, "R4 len8");
    sendRx(1'b1, 1'b1, 2, 32'h0000_FFFF, "R4 len16");

    // R5: invalid lengths under low alignment
    writeCfg(1'b1, 3);
    chk("R5 err len24", {31'd0, lenError}, 32'd1);
    writeCfg(1'b1, 2);
    chk("R5 err len16", {31'd0, lenError}, 32'd0);
    sendRx(1'b1, 1'b1, 4, 32'hFFFF_FFFF, "R5 fallback32");
    chk("R5 err len32", {31'd0, lenError}, 32'd1);

    // R6: software reset clears alignment, keeps length
    writeCfg(1'b1, 3);
    @(negedge clk); softRst = 1'b1;
    @(negedge clk); softRst = 1'b0;
    chk("R6 align cleared", {31'd0, alignBit}, 32'd0);
    chk("R6 err cleared", {31'd0, lenError}, 32'd0);
    writeCfg(1'b1, 2);
    @(negedge clk); softRst = 1'b1; cfgWe = 1'b1; cfgAlign = 1'b1; cfgLen = 3'd2;
    @(negedge clk); softRst = 1'b0; cfgWe = 1'b0;
    chk("R6 priority", {31'd0, alignBit}, 32'd0);
    sendRx(1'b0, 1'b0, 2, 32'h0000_9C3D, "R6 length kept");

    // R8: restart mid-word, then stray bits ignored
    writeCfg(1'b0, 0);
    bitStep(1'b1, 1'b1, 0);
    bitStep(1'b0, 1'b1, 1);
    bitStep(1'b0, 1'b1, 0);
    sendRx(1'b0, 1'b0, 0, 32'h0000_00A5, "R8 restart");
    for (int i = 0; i < 5; i++) begin
      bitStep(1'b0, 1'b1, 0);
      chk("R8 stray valid", {31'd0, rxValid}, 32'd0);
    end
    chk("R8 stray word", {8'd0, rxWord}, 32'h00A5_0000);

    // R7 / R9 directed transmit
    sendTx(1'b0, 3, 24'hA5C3_96, 1'b1);
    sendTx(1'b1, 2, 24'h12B7_E1, 1'b1);
    sendTx(1'b1, 4, 24'hF0_0F_81, 1'b0);

    // constrained random receive and transmit
    for (int r = 0; r < 30; r++) begin
      int code = $urandom_range(0, 7);
      bit al = 1'($urandom_range(0, 1));
      sendRx(1'b1, al, code, $urandom(), "R3 R4 random");
    end
    for (int r = 0; r < 10; r++) begin
      int code = $urandom_range(0, 7);
      bit al = 1'($urandom_range(0, 1));
      sendTx(al, code, 24'($urandom()), 1'b0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule